// File: doc/BRIEF.md
# Single-Wire Return-to-One Register Slave

This block is the device end of a single-wire serial link where every bit begins with a falling edge and ends with the line going high again. A bit's value lies in how long the line stays low: a short low is a 1 and a long low is a 0. The block samples the line through a synchroniser and measures each low pulse in clock cycles. It assembles bytes least-significant bit first and treats the first byte of each transaction as a command.

A command with its top bit set names a register and stores the next received byte there. A command with its top bit clear makes the block wait a programmable number of cycles and then send back the addressed register's eight bits, driving the line low itself through an open-drain pull-down enable. An over-long low pulse resynchronises the link. A pulse longer than a valid 0 but shorter than a break is a framing error and discards the byte in progress. A pulse reaching the break length aborts everything and mutes the receiver until the line has been high for a recovery time.

All timing is given as parameters in clock cycles. The register file is internal and its depth is a parameter, a power of two of at most 128.

Top module: `owire_slave`

## Requirements
- R1: While reset is asserted and after its release, `line_pull_o` is 0. Every register of the file reads 0x00, and the block accepts a command at once without needing a break first.
- R2: Bytes are assembled least-significant bit first. Command bit 7 = 1 means write and 0 means read. The register index is command bits [AW-1:0] with AW = log2(DEPTH); command bits 6 down to AW are ignored (with DEPTH 16, command 0x92 addresses register 2).
- R3: After a write command, the next eight received bits are stored in the addressed register, and the following byte is again taken as a command.
- R4: A low pulse of width w clock cycles (as seen at `line_i`) decodes as 1 when w < THR, with THR = (LOW1_CYC + LOW0_CYC)/2 (40 by default). It decodes as 0 when THR <= w <= MAXLOW_CYC.
- R5: A pulse with MAXLOW_CYC < w < BREAK_CYC is a framing error. The partial byte and the transaction are discarded, and the very next pulse starts a new command with no recovery wait.
- R6: A low lasting BREAK_CYC cycles or more aborts any partial command or data. Pulses are ignored until the line has then been high for BRECOV_CYC consecutive cycles.
- R7: After a read command, the register's eight bits are sent least-significant first in slots of BIT_CYC cycles. Each slot starts with `line_pull_o` high for LOW1_CYC cycles for a 1 or LOW0_CYC cycles for a 0, then low for the rest of the slot. The block then returns to waiting for a command.
- R8: If the host releases the line after clock edge E at the end of a read command's last bit, `line_pull_o` first rises after edge E + TURN_CYC + 3. The 3 cycles are the two-flop input synchroniser plus one decode register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Level of the shared line (wired-AND of host and device) |
| line_pull_o | output | 1 | 1 = device pulls the shared line low |

## Verification
The hardest condition to reach from the ports is the narrow window around a break. A pulse that arrives after the break but before the recovery time has elapsed must be dropped. A pulse one cycle shorter than the break must instead count as a framing error that needs no recovery. The bench reaches the first case by ending a break with only a short high gap, sending one stray bit and then a full read. It reaches the second by sending a BREAK_CYC-1 pulse followed at once by a read. In each case a miscounted bit shifts the turnaround, so the cycle-exact comparison of `line_pull_o` against the model exposes it.

// File: rtl/owire_pkg.sv
`timescale 1ns/1ps
package owire_pkg;

  typedef enum logic [2:0] {
    ST_BRK,
    ST_CMD,
    ST_WDATA,
    ST_TURN,
    ST_TX
  } ow_state_e;

  typedef enum logic [1:0] {
    PW_ONE,
    PW_ZERO,
    PW_FRAME,
    PW_BREAK
  } pw_class_e;

  // decision point between a short and a long low pulse
  function automatic int unsigned bit_threshold(input int unsigned low1,
                                                input int unsigned low0);
    return (low1 + low0) / 2;
  endfunction

  // class of a completed low pulse of w cycles
  function automatic pw_class_e classify_width(input int unsigned w,
                                               input int unsigned thr,
                                               input int unsigned maxlow,
                                               input int unsigned brk);
    if (w < thr)           return PW_ONE;
    else if (w <= maxlow)  return PW_ZERO;
    else if (w < brk)      return PW_FRAME;
    else                   return PW_BREAK;
  endfunction

  // device low time for one transmitted bit
  function automatic int unsigned tx_low_len(input logic b,
                                             input int unsigned low1,
                                             input int unsigned low0);
    return b ? low1 : low0;
  endfunction

endpackage

// File: rtl/owire_sync.sv
`timescale 1ns/1ps
module owire_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic rise
);

  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], line_i};
  end

  assign line_s = pipe[STAGES-1];
  assign rise   = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/owire_pulse_meter.sv
`timescale 1ns/1ps
module owire_pulse_meter
  import owire_pkg::*;
#(
  parameter int unsigned THR_CYC    = 40,
  parameter int unsigned MAXLOW_CYC = 100,
  parameter int unsigned BREAK_CYC  = 200,
  parameter int unsigned BRECOV_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic rise,
  output logic bit_evt,
  output logic bit_val,
  output logic frame_evt,
  output logic brk_evt,
  output logic recov_evt
);

  localparam int unsigned LW = $clog2(BREAK_CYC + 1);
  localparam int unsigned HW = $clog2(BRECOV_CYC + 1);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] hi_cnt;
  logic          brk_pend;
  pw_class_e     cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      hi_cnt   <= '0;
      brk_pend <= 1'b0;
    end else begin
      if (!line_s) begin
        if (low_cnt != LW'(BREAK_CYC)) low_cnt <= low_cnt + LW'(1);
        hi_cnt <= '0;
      end else begin
        low_cnt <= '0;
        if (hi_cnt != HW'(BRECOV_CYC)) hi_cnt <= hi_cnt + HW'(1);
      end
      if (brk_evt)        brk_pend <= 1'b1;
      else if (recov_evt) brk_pend <= 1'b0;
    end
  end

  // low_cnt holds the finished pulse width in the cycle the rise is seen
  assign cls       = classify_width(32'(low_cnt), THR_CYC, MAXLOW_CYC, BREAK_CYC);
  assign bit_evt   = rise && (cls == PW_ONE || cls == PW_ZERO);
  assign bit_val   = (cls == PW_ONE);
  assign frame_evt = rise && (cls == PW_FRAME);
  assign brk_evt   = !line_s && (low_cnt == LW'(BREAK_CYC - 1));
  assign recov_evt = brk_pend && line_s && (hi_cnt == HW'(BRECOV_CYC - 1));

endmodule

// File: rtl/owire_regfile.sv
`timescale 1ns/1ps
module owire_regfile #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_data = mem[addr];

endmodule

// File: rtl/owire_link_ctrl.sv
`timescale 1ns/1ps
module owire_link_ctrl
  import owire_pkg::*;
#(
  parameter int unsigned AW       = 4,
  parameter int unsigned LOW1_CYC = 20,
  parameter int unsigned LOW0_CYC = 60,
  parameter int unsigned BIT_CYC  = 120,
  parameter int unsigned TURN_CYC = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_evt,
  input  logic          bit_val,
  input  logic          frame_evt,
  input  logic          brk_evt,
  input  logic          recov_evt,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] addr,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          pull,
  output ow_state_e     state
);

  localparam int unsigned TMAX = (BIT_CYC > TURN_CYC) ? BIT_CYC : TURN_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  ow_state_e     st;
  logic [7:0]    shreg;
  logic [2:0]    bcnt;
  logic [AW-1:0] addr_q;
  logic [7:0]    txreg;
  logic [2:0]    tbit;
  logic [TW-1:0] tcnt;
  logic [7:0]    rx_byte;
  logic          rx_state;

  assign rx_byte  = {bit_val, shreg[7:1]};
  assign rx_state = (st == ST_CMD) || (st == ST_WDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_CMD;
      shreg  <= '0;
      bcnt   <= '0;
      addr_q <= '0;
      txreg  <= '0;
      tbit   <= '0;
      tcnt   <= '0;
    end else if (brk_evt) begin
      st   <= ST_BRK;
      bcnt <= '0;
    end else begin
      unique case (st)
        ST_BRK: begin
          if (recov_evt) begin
            st   <= ST_CMD;
            bcnt <= '0;
          end
        end
        ST_CMD, ST_WDATA: begin
          if (frame_evt) begin
            st   <= ST_CMD;
            bcnt <= '0;
          end else if (bit_evt) begin
            shreg <= rx_byte;
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              if (st == ST_WDATA) begin
                st <= ST_CMD;
              end else begin
                addr_q <= rx_byte[AW-1:0];
                tcnt   <= '0;
                st     <= rx_byte[7] ? ST_WDATA : ST_TURN;
              end
            end
          end
        end
        ST_TURN: begin
          if (tcnt == TW'(TURN_CYC - 1)) begin
            st    <= ST_TX;
            tcnt  <= '0;
            tbit  <= '0;
            txreg <= rd_data;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        ST_TX: begin
          if (tcnt == TW'(BIT_CYC - 1)) begin
            tcnt <= '0;
            if (tbit == 3'd7) begin
              st   <= ST_CMD;
              bcnt <= '0;
            end else begin
              tbit  <= tbit + 3'd1;
              txreg <= {1'b0, txreg[7:1]};
            end
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        default: st <= ST_CMD;
      endcase
    end
  end

  assign wr_en   = (st == ST_WDATA) && bit_evt && (bcnt == 3'd7) && !brk_evt;
  assign wr_data = rx_byte;
  assign addr    = addr_q;
  assign pull    = (st == ST_TX) &&
                   (32'(tcnt) < tx_low_len(txreg[0], LOW1_CYC, LOW0_CYC));
  assign state   = st;

endmodule

// File: rtl/owire_slave.sv
`timescale 1ns/1ps
module owire_slave
  import owire_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned LOW1_CYC   = 20,
  parameter int unsigned LOW0_CYC   = 60,
  parameter int unsigned MAXLOW_CYC = 100,
  parameter int unsigned BREAK_CYC  = 200,
  parameter int unsigned BRECOV_CYC = 40,
  parameter int unsigned BIT_CYC    = 120,
  parameter int unsigned TURN_CYC   = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_pull_o
);

  localparam int unsigned AW      = $clog2(DEPTH);
  localparam int unsigned THR_CYC = bit_threshold(LOW1_CYC, LOW0_CYC);

  // named internal events, also observed by the bound checker
  logic          line_s;
  logic          rise;
  logic          bit_evt;
  logic          bit_val;
  logic          frame_evt;
  logic          brk_evt;
  logic          recov_evt;
  logic          wr_en;
  logic [AW-1:0] reg_addr;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  ow_state_e     state;

  owire_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .line_s (line_s),
    .rise   (rise)
  );

  owire_pulse_meter #(
    .THR_CYC    (THR_CYC),
    .MAXLOW_CYC (MAXLOW_CYC),
    .BREAK_CYC  (BREAK_CYC),
    .BRECOV_CYC (BRECOV_CYC)
  ) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_s    (line_s),
    .rise      (rise),
    .bit_evt   (bit_evt),
    .bit_val   (bit_val),
    .frame_evt (frame_evt),
    .brk_evt   (brk_evt),
    .recov_evt (recov_evt)
  );

  owire_link_ctrl #(
    .AW       (AW),
    .LOW1_CYC (LOW1_CYC),
    .LOW0_CYC (LOW0_CYC),
    .BIT_CYC  (BIT_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_evt   (bit_evt),
    .bit_val   (bit_val),
    .frame_evt (frame_evt),
    .brk_evt   (brk_evt),
    .recov_evt (recov_evt),
    .rd_data   (rd_data),
    .addr      (reg_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .pull      (line_pull_o),
    .state     (state)
  );

  owire_regfile #(.DEPTH(DEPTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (reg_addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/owire_slave_chk.sv
`timescale 1ns/1ps
module owire_slave_chk
  import owire_pkg::*;
#(
  parameter int unsigned LOW0_CYC = 60
) (
  input logic      clk,
  input logic      rst_n,
  input logic      line_pull_o,
  input ow_state_e state,
  input logic      bit_evt,
  input logic      frame_evt,
  input logic      brk_evt,
  input logic      recov_evt,
  input logic      wr_en
);

  logic [15:0] pull_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pull_run <= '0;
    else if (line_pull_o) pull_run <= pull_run + 16'd1;
    else                  pull_run <= '0;
  end

  // R5
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_evt, frame_evt, brk_evt, recov_evt}));

  // R6
  break_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> (state == ST_BRK));

  // R5
  frame_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_evt && (state == ST_CMD || state == ST_WDATA)) |=> (state == ST_CMD));

  // R3
  write_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (state == ST_CMD));

  // R7
  pull_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_o |-> (pull_run < 16'(LOW0_CYC)));

  // R8
  tx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && $past(state) == ST_TURN) |-> line_pull_o);

endmodule

bind owire_slave owire_slave_chk #(.LOW0_CYC(LOW0_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_pull_o (line_pull_o),
  .state       (state),
  .bit_evt     (bit_evt),
  .frame_evt   (frame_evt),
  .brk_evt     (brk_evt),
  .recov_evt   (recov_evt),
  .wr_en       (wr_en)
);

// File: tb/sim_owire_slave.sv
`timescale 1ns/1ps
module sim_owire_slave;

  localparam int DEPTH      = 16;
  localparam int LOW1_CYC   = 20;
  localparam int LOW0_CYC   = 60;
  localparam int MAXLOW_CYC = 100;
  localparam int BREAK_CYC  = 200;
  localparam int BRECOV_CYC = 40;
  localparam int BIT_CYC    = 120;
  localparam int TURN_CYC   = 50;
  localparam int THR        = 40;   // (LOW1_CYC + LOW0_CYC) / 2
  localparam int H1         = 12;   // host low time for a 1
  localparam int H0         = 52;   // host low time for a 0
  localparam int HOST_BIT   = 100;
  localparam int GAP        = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_drv = 1'b1;
  logic pull;
  logic line;

  assign line = host_drv & ~pull;

  owire_slave #(
    .DEPTH(DEPTH), .LOW1_CYC(LOW1_CYC), .LOW0_CYC(LOW0_CYC),
    .MAXLOW_CYC(MAXLOW_CYC), .BREAK_CYC(BREAK_CYC), .BRECOV_CYC(BRECOV_CYC),
    .BIT_CYC(BIT_CYC), .TURN_CYC(TURN_CYC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line), .line_pull_o(pull)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0;
  int miscmp = 0;
  bit done = 1'b0;
  int last_rel = 0;
  int exp_start = -1;
  logic [7:0] exp_byte = 8'h00;
  logic [7:0] model_mem [DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  endtask

  // behavioural expectation of the device pull for cycle c (R7 slot shape)
  function automatic bit exp_pull_at(input int c);
    int d;
    int b;
    if (exp_start < 0) return 1'b0;
    d = c - exp_start;
    if (d < 0 || d >= 8 * BIT_CYC) return 1'b0;
    b = d / BIT_CYC;
    return (d % BIT_CYC) < (exp_byte[b] ? LOW1_CYC : LOW0_CYC);
  endfunction

  // every-clock comparison of the pull output against the model (R7, R8)
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (pull !== exp_pull_at(cyc)) begin
        miscmp++;
        $display("FAIL R7 pull at cycle %0d: actual %0h expected %0h",
                 cyc, pull, exp_pull_at(cyc));
      end
    end
  end

  task automatic host_low(input int w, input int hi);
    @(posedge clk); #1 host_drv = 1'b0;
    repeat (w) @(posedge clk);
    #1 host_drv = 1'b1;
    last_rel = cyc;
    repeat (hi) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    host_low(b ? H1 : H0, HOST_BIT - (b ? H1 : H0));
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    send_byte(8'h80 | (8'(a) & 8'h7F));
    send_byte(d);
    model_mem[a % DEPTH] = d;
  endtask

  task automatic do_read(input int a, input string req);
    logic [7:0] cmd;
    logic [7:0] got;
    cmd = 8'(a) & 8'h7F;
    for (int i = 0; i < 7; i++) send_bit(cmd[i]);
    host_low(cmd[7] ? H1 : H0, 0);
    exp_byte  = model_mem[a % DEPTH];
    exp_start = last_rel + 3 + TURN_CYC;
    while (cyc < exp_start - 1) @(negedge clk);
    check(pull == 1'b0, "R8", "pull before turnaround ends", pull, 0);
    @(negedge clk);
    check(pull == 1'b1, "R8", "pull at turnaround end", pull, 1);
    for (int i = 0; i < 8; i++) begin
      while (cyc < exp_start + i * BIT_CYC + THR) @(negedge clk);
      got[i] = ~pull;
    end
    while (cyc < exp_start + 8 * BIT_CYC + 5) @(negedge clk);
    check(got == exp_byte, req, $sformatf("read of register %0d", a), got, exp_byte);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(pull == 1'b0, "R1", "pull during reset", pull, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pull == 1'b0, "R1", "pull after reset", pull, 0);

    // R1: register file clear, command accepted without break
    do_read(5, "R1");

    // R3, R7: plain write then read, several data patterns
    do_write(3, 8'hA5);
    do_read(3, "R3");
    do_write(0, 8'h3C);
    do_write(15, 8'hFF);
    do_read(15, "R3");
    do_read(0, "R7");

    // R2: command bits above the index are ignored (0x12 -> register 2)
    do_write(8'h12, 8'h5A);
    do_read(2, "R2");

    // R4: width boundaries, bits 1,0,0,1,1,1,0,0 -> 0x39
    send_byte(8'h87);
    host_low(THR - 1, GAP);
    host_low(THR, GAP);
    host_low(MAXLOW_CYC, GAP);
    host_low(1, GAP);
    host_low(H1, GAP);
    host_low(H1, GAP);
    host_low(H0, GAP);
    host_low(H0, GAP);
    model_mem[7] = 8'h39;
    do_read(7, "R4");

    // R5: framing error as first data bit, register keeps old value
    send_byte(8'h84);
    host_low(MAXLOW_CYC + 1, GAP);
    do_read(4, "R5");

    // R5: framing error mid-command, one cycle short of a break, short gap
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    host_low(BREAK_CYC - 1, 10);
    do_read(3, "R5");

    // R6: break in the middle of a command
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    host_low(BREAK_CYC + 10, BRECOV_CYC + 10);
    do_read(15, "R6");

    // R6: break in the middle of write data, register unchanged
    send_byte(8'h83);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    host_low(BREAK_CYC, BRECOV_CYC + 5);
    do_read(3, "R6");

    // R6: stray bit before recovery has elapsed is ignored
    host_low(BREAK_CYC, 10);
    send_bit(1'b0);
    do_read(0, "R6");

    // R3 after all the aborts: a fresh write still lands
    do_write(9, 8'hC3);
    do_read(9, "R3");

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

endmodule